// File: doc/BRIEF.md
# Multiplexed Readout Slot Sequencer

This block walks a shared differential readout line through an ordered list of measurement slots, one slot for each rising edge of an external select strobe. For every step it reports which slot is current, whether the amplifier inputs should be swapped, whether this device may drive the shared output line, and a start-of-sequence marker. The slot list is built from a per-channel enable mask (each enabled channel gives a bus-voltage slot and a shunt-current slot), two optional auxiliary inputs and an optional ground calibration slot. Leading and trailing idle slots let two devices share one output line, each staying off the line while its partner drives it.

Settings arrive as plain inputs from a register block. The sequencer copies them into shadow storage only when a sequence starts, so a sequence in progress never changes shape. An optional idle timeout returns the position to the start when the strobe stops moving. The enable mode holds the sequencer in reset whenever the device is not fully on.

Top module: `slot_sequencer`

## Requirements
- R1: The position advances by exactly one slot on each rising edge of `selIn` seen on `clk`. A falling edge, or a level held with the timeout off, leaves `slotId` unchanged.
- R2: Slot codes: channel i (0-based) gives bus voltage = 2i and shunt current = 2i+1, in channel order. Auxiliary input a gives 2*NUM_CH+a. Calibration gives 2*NUM_CH+NUM_AUX (10 by default). Disabled entries are omitted. The idle code is all ones (15 by default).
- R3: `leadSkip` = N adds N slots before the list and `tailSkip` = M adds M slots after it. In those slots `slotId` shows the idle code and `drvEn` is 0. `drvEn` is 1 only in a measurement slot.
- R4: With `altPolarity` set, a sequence runs its whole list (skips included) twice. `polRev` is 0 in the first pass and 1 in the second.
- R5: With `timeoutOff` = 0, `selIn` held at one level for TIMEOUT_TICKS cycles returns the sequencer to idle. The next rising edge starts a new sequence at slot 0 using the current settings.
- R6: With `timeoutOff` = 1, a held level never resets the position. The sequence wraps to its first slot only after every slot has been clocked.
- R7: `syncOut` is 1 during the first slot of each sequence except the first sequence after reset or after the enable mode leaves full operation. It is 0 in every other slot.
- R8: Settings are captured on the rising edge that starts a sequence. Changes made during a sequence have no effect until the next sequence starts.
- R9: `enState` encoding: 2'b00 full operation, 2'b01 limited, 2'b10/2'b11 standby. In any mode other than full, the sequencer is held idle with `drvEn` = 0 and `syncOut` = 0. Returning to full starts again from slot 0.
- R10: An empty list (no channels, no auxiliaries, no skips) gives the calibration slot alone when calibration is enabled. Otherwise it keeps `drvEn` at 0 with the idle code.
- R11: After reset, and before the first rising edge, `slotId` is the idle code and `drvEn`, `polRev` and `syncOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enState | input | 2 | Enable mode: 00 full, 01 limited, 1x standby |
| selIn | input | 1 | Select strobe, already synchronous to clk |
| chanEnable | input | NUM_CH | Per-channel enable (bus + shunt slots) |
| auxEnable | input | NUM_AUX | Auxiliary input slot enables |
| calEnable | input | 1 | Append ground calibration slot |
| leadSkip | input | SKIP_W | Count of leading undriven slots |
| tailSkip | input | SKIP_W | Count of trailing undriven slots |
| altPolarity | input | 1 | Run a second, reversed-polarity pass |
| timeoutOff | input | 1 | 1 disables the idle timeout |
| slotId | output | ID_W | Current slot code (all ones = idle/skip) |
| polRev | output | 1 | Amplifier inputs swapped |
| drvEn | output | 1 | Drive the shared output line |
| syncOut | output | 1 | First slot of a non-first sequence |

## Verification
Two functions can fall on the same clock edge: a settings change and the rising edge that wraps or restarts the sequence. The bench changes the channel mask in the middle of a sequence. It checks that the remaining slots still follow the old mask, and that the new mask appears exactly at the first slot after the wrap. The timeout restart and a pending mask change meet in the same way: the bench changes the mask while the strobe is idle and expects the restarted sequence to use the new mask, with the start marker high because this is not the first sequence.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic [1:0] {
    EN_FULL    = 2'b00,
    EN_LIMITED = 2'b01,
    EN_STANDBY = 2'b10
  } en_mode_e;

  typedef struct packed {
    logic clear;   // hold in reset (not fully enabled)
    logic goIdle;  // idle timeout expired
    logic start;   // begin a new sequence, capture settings
    logic step;    // advance one slot
  } seq_strobe_t;

endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 45000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  enState,
  input  logic        selIn,
  input  logic        timeoutOff,
  input  logic        active,
  input  logic        lastSlot,
  output seq_strobe_t strb
);
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_TICKS - 1);

  logic             selPrev;
  logic [CNT_W-1:0] idleCnt;
  logic             enFull, selRise, selEdge, timeoutHit;

  assign enFull     = (enState == EN_FULL);
  assign selRise    = selIn & ~selPrev;
  assign selEdge    = selIn ^ selPrev;
  assign timeoutHit = enFull & active & ~timeoutOff & ~selEdge & (idleCnt == CNT_MAX);

  always_comb begin
    strb        = '0;
    strb.clear  = ~enFull;
    strb.goIdle = timeoutHit;
    strb.start  = enFull & selRise & (~active | lastSlot);
    strb.step   = enFull & selRise & active & ~lastSlot;
  end

  always_ff @(posedge clk) begin
    selPrev <= selIn;
    if (!rstN || !enFull || !active || selEdge) begin
      idleCnt <= '0;
    end else if (idleCnt != CNT_MAX) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

endmodule

// File: rtl/slot_seq_datapath.sv
module slot_seq_datapath
  import slot_seq_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_AUX = 2,
  parameter int SKIP_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strb,
  input  logic [NUM_CH-1:0]   chanEnable,
  input  logic [NUM_AUX-1:0]  auxEnable,
  input  logic                calEnable,
  input  logic [SKIP_W-1:0]   leadSkip,
  input  logic [SKIP_W-1:0]   tailSkip,
  input  logic                altPolarity,
  output logic                active,
  output logic                lastSlot,
  output logic [$clog2(2*NUM_CH+NUM_AUX+2)-1:0] slotId,
  output logic                polRev,
  output logic                drvEn,
  output logic                syncOut
);
  localparam int N_ENT    = 2*NUM_CH + NUM_AUX + 1;
  localparam int ID_W     = $clog2(N_ENT + 1);
  localparam int SKIP_MAX = (1 << SKIP_W) - 1;
  localparam int POS_W    = $clog2(2*(2*SKIP_MAX + N_ENT) + 1);
  localparam logic [ID_W-1:0] IDLE_ID = '1;

  // shadow settings captured at sequence start
  logic [NUM_CH-1:0]  chanS;
  logic [NUM_AUX-1:0] auxS;
  logic               calS, altS;
  logic [SKIP_W-1:0]  leadS, tailS;

  logic [POS_W-1:0] pos;
  logic             startedOnce, syncArm;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      active <= 1'b0; pos <= '0; startedOnce <= 1'b0; syncArm <= 1'b0;
      chanS <= '0; auxS <= '0; calS <= 1'b0; altS <= 1'b0;
      leadS <= '0; tailS <= '0;
    end else if (strb.goIdle) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (strb.start) begin
      active      <= 1'b1;
      pos         <= '0;
      syncArm     <= startedOnce;
      startedOnce <= 1'b1;
      chanS <= chanEnable; auxS <= auxEnable; calS <= calEnable;
      altS  <= altPolarity; leadS <= leadSkip; tailS <= tailSkip;
    end else if (strb.step) begin
      pos <= pos + 1'b1;
    end
  end

  // slot list decode
  logic [N_ENT-1:0] enVec;
  logic [POS_W-1:0] measCnt, listLen, totalLen, qPos, kIdx, seen, leadP;
  logic             secondPass, inMeas;
  logic [ID_W-1:0]  measId;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      enVec[2*i]   = chanS[i];
      enVec[2*i+1] = chanS[i];
    end
    for (int a = 0; a < NUM_AUX; a++) enVec[2*NUM_CH+a] = auxS[a];
    enVec[N_ENT-1] = calS;

    measCnt = '0;
    for (int i = 0; i < N_ENT; i++) measCnt = measCnt + POS_W'(enVec[i]);

    leadP      = POS_W'(leadS);
    listLen    = leadP + measCnt + POS_W'(tailS);
    totalLen   = altS ? (listLen << 1) : listLen;
    secondPass = altS && (pos >= listLen);
    qPos       = secondPass ? (pos - listLen) : pos;
    inMeas     = (qPos >= leadP) && ((qPos - leadP) < measCnt);
    kIdx       = qPos - leadP;

    measId = IDLE_ID;
    seen   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (enVec[i]) begin
        if (seen == kIdx) measId = ID_W'(i);
        seen = seen + 1'b1;
      end
    end
  end

  assign lastSlot = (totalLen == '0) || (pos == totalLen - 1'b1);
  assign drvEn    = active && inMeas && (totalLen != '0);
  assign slotId   = drvEn ? measId : IDLE_ID;
  assign polRev   = active && secondPass;
  assign syncOut  = active && syncArm && (pos == '0) && (totalLen != '0);

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_seq_pkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int NUM_AUX       = 2,
  parameter int SKIP_W        = 4,
  parameter int TIMEOUT_TICKS = 45000,
  localparam int ID_W         = $clog2(2*NUM_CH + NUM_AUX + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         enState,
  input  logic               selIn,
  input  logic [NUM_CH-1:0]  chanEnable,
  input  logic [NUM_AUX-1:0] auxEnable,
  input  logic               calEnable,
  input  logic [SKIP_W-1:0]  leadSkip,
  input  logic [SKIP_W-1:0]  tailSkip,
  input  logic               altPolarity,
  input  logic               timeoutOff,
  output logic [ID_W-1:0]    slotId,
  output logic               polRev,
  output logic               drvEn,
  output logic               syncOut
);
  seq_strobe_t strb;
  logic        active, lastSlot;

  slot_seq_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enState(enState), .selIn(selIn),
    .timeoutOff(timeoutOff), .active(active), .lastSlot(lastSlot), .strb(strb)
  );

  slot_seq_datapath #(.NUM_CH(NUM_CH), .NUM_AUX(NUM_AUX), .SKIP_W(SKIP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .chanEnable(chanEnable), .auxEnable(auxEnable), .calEnable(calEnable),
    .leadSkip(leadSkip), .tailSkip(tailSkip), .altPolarity(altPolarity),
    .active(active), .lastSlot(lastSlot), .slotId(slotId),
    .polRev(polRev), .drvEn(drvEn), .syncOut(syncOut)
  );

endmodule

// File: rtl/slot_sequencer_chk.sv
module slot_sequencer_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      enState,
  input logic            selIn,
  input logic            timeoutOff,
  input logic [ID_W-1:0] slotId,
  input logic            polRev,
  input logic            drvEn,
  input logic            syncOut
);
  localparam logic [ID_W-1:0] IDLE_ID = '1;

  AST_DRV_HAS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> (slotId != IDLE_ID)); // R3

  AST_OFF_WHEN_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (enState != 2'b00) |=> (!drvEn && !syncOut)); // R9

  AST_SYNC_NORMAL_POL: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |-> !polRev); // R7

  AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ((enState == 2'b00) && timeoutOff && !(selIn && !$past(selIn))) |=> $stable(slotId)); // R1

endmodule

bind slot_sequencer slot_sequencer_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .enState(enState), .selIn(selIn), .timeoutOff(timeoutOff),
  .slotId(slotId), .polRev(polRev), .drvEn(drvEn), .syncOut(syncOut)
);

// File: tb/tb_slot_sequencer.sv
module tb_slot_sequencer;
  localparam int TICKS = 40;
  localparam logic [3:0] IDLE = 4'hF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] enState = 2'b00;
  logic       selIn = 1'b0;
  logic [3:0] chanEnable = 4'hF;
  logic [1:0] auxEnable = 2'b00;
  logic       calEnable = 1'b0;
  logic [3:0] leadSkip = 4'd0, tailSkip = 4'd0;
  logic       altPolarity = 1'b0, timeoutOff = 1'b1;
  logic [3:0] slotId;
  logic       polRev, drvEn, syncOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slot_sequencer #(.TIMEOUT_TICKS(TICKS)) dut (
    .clk(clk), .rstN(rstN), .enState(enState), .selIn(selIn),
    .chanEnable(chanEnable), .auxEnable(auxEnable), .calEnable(calEnable),
    .leadSkip(leadSkip), .tailSkip(tailSkip), .altPolarity(altPolarity),
    .timeoutOff(timeoutOff), .slotId(slotId), .polRev(polRev),
    .drvEn(drvEn), .syncOut(syncOut)
  );

  // row: chan[25:22] aux[21:20] cal[19] lead[18:15] tail[14:11] alt[10]
  //      pulses[9:6] expId[5:2] expDrv[1] expPol[0]
  localparam logic [25:0] VEC [15] = '{
    {4'hF, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd1, 4'd0, 1'b1, 1'b0},  // R1 R2
    {4'hF, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd8, 4'd7, 1'b1, 1'b0},  // R2
    {4'h9, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd3, 4'd6, 1'b1, 1'b0},  // R2 mask gap
    {4'h9, 2'b11, 1'b1, 4'd0, 4'd0, 1'b0, 4'd5, 4'd8, 1'b1, 1'b0},  // R2 aux
    {4'h9, 2'b11, 1'b1, 4'd0, 4'd0, 1'b0, 4'd7, 4'd10, 1'b1, 1'b0}, // R2 cal
    {4'h1, 2'b00, 1'b0, 4'd2, 4'd0, 1'b0, 4'd1, IDLE, 1'b0, 1'b0},  // R3 lead
    {4'h1, 2'b00, 1'b0, 4'd2, 4'd0, 1'b0, 4'd3, 4'd0, 1'b1, 1'b0},  // R3
    {4'h1, 2'b00, 1'b0, 4'd0, 4'd1, 1'b0, 4'd3, IDLE, 1'b0, 1'b0},  // R3 tail
    {4'h1, 2'b00, 1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 4'd0, 1'b1, 1'b1},  // R4
    {4'h1, 2'b00, 1'b0, 4'd1, 4'd1, 1'b1, 4'd6, 4'd0, 1'b1, 1'b1},  // R4 skips
    {4'h1, 2'b00, 1'b0, 4'd1, 4'd1, 1'b1, 4'd8, IDLE, 1'b0, 1'b1},  // R4 tail pass2
    {4'h0, 2'b00, 1'b1, 4'd0, 4'd0, 1'b0, 4'd1, 4'd10, 1'b1, 1'b0}, // R10 cal only
    {4'h0, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd1, IDLE, 1'b0, 1'b0},  // R10 empty
    {4'h2, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd2, 4'd3, 1'b1, 1'b0},  // R2
    {4'h3, 2'b00, 1'b0, 4'd0, 4'd0, 1'b0, 4'd5, 4'd0, 1'b1, 1'b0}   // R6 wrap
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) selIn = 1'b1;
    @(negedge clk) selIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic restart();
    @(negedge clk) enState = 2'b10;
    @(negedge clk);
    @(negedge clk) enState = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 id", 8'(slotId), 8'(IDLE));
    chk("R11 drv/pol/sync", {5'd0, drvEn, polRev, syncOut}, 8'd0);

    foreach (VEC[r]) begin
      chanEnable  = VEC[r][25:22];
      auxEnable   = VEC[r][21:20];
      calEnable   = VEC[r][19];
      leadSkip    = VEC[r][18:15];
      tailSkip    = VEC[r][14:11];
      altPolarity = VEC[r][10];
      restart();
      for (int p = 0; p < int'(VEC[r][9:6]); p++) pulse();
      chk($sformatf("R2/R3/R4 row %0d id", r), 8'(slotId), 8'(VEC[r][5:2]));
      chk($sformatf("R3/R4 row %0d drv,pol", r), {6'd0, drvEn, polRev}, {6'd0, VEC[r][1:0]});
    end
    altPolarity = 1'b0; leadSkip = 0; tailSkip = 0; auxEnable = 0; calEnable = 0;

    // R1: falling edge and held level do not move
    chanEnable = 4'h3; timeoutOff = 1'b1;
    restart();
    @(negedge clk) selIn = 1'b1;
    @(negedge clk);
    chk("R1 rise", 8'(slotId), 8'd0);
    repeat (TICKS + 10) @(negedge clk);
    selIn = 1'b0;
    @(negedge clk);
    chk("R1 fall/hold", 8'(slotId), 8'd0);
    chk("R7 first sequence no sync", 8'(syncOut), 8'd0);

    // R6: held level with timeout off, then wrap after all slots
    pulse();
    repeat (TICKS + 10) @(negedge clk);
    pulse();
    chk("R6 no reset", 8'(slotId), 8'd2);
    pulse();
    pulse();
    chk("R6 wrap", 8'(slotId), 8'd0);
    chk("R7 second sequence sync", 8'(syncOut), 8'd1);
    pulse();
    chk("R7 sync only first slot", 8'(syncOut), 8'd0);

    // R5: timeout restart with pending settings
    timeoutOff = 1'b0;
    chanEnable = 4'h4;
    repeat (TICKS + 10) @(negedge clk);
    pulse();
    chk("R5 restart new cfg", 8'(slotId), 8'd4);
    chk("R5 sync after timeout", 8'(syncOut), 8'd1);
    timeoutOff = 1'b1;

    // R8: mid-sequence change
    chanEnable = 4'hF;
    restart();
    pulse();
    chanEnable = 4'h1;
    pulse();
    pulse();
    chk("R8 old cfg held", 8'(slotId), 8'd2);
    repeat (5) pulse();
    chk("R8 old cfg end", 8'(slotId), 8'd7);
    pulse();
    pulse();
    chk("R8 new cfg slot1", 8'(slotId), 8'd1);
    pulse();
    chk("R8 new cfg wrap", 8'(slotId), 8'd0);

    // R9: limited mode mid-sequence
    chanEnable = 4'h3;
    pulse();
    @(negedge clk) enState = 2'b01;
    @(negedge clk);
    chk("R9 limited id", 8'(slotId), 8'(IDLE));
    chk("R9 limited drv", 8'(drvEn), 8'd0);
    @(negedge clk) enState = 2'b00;
    pulse();
    chk("R9 re-enable start", 8'(slotId), 8'd0);
    chk("R9 re-enable no sync", 8'(syncOut), 8'd0);
    @(negedge clk) enState = 2'b11;
    @(negedge clk);
    chk("R9 standby drv", {6'd0, drvEn, syncOut}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule